// File: doc/BRIEF.md
# External Pin Interrupt Sense Detector

This block watches a single external interrupt pin and turns its activity into an interrupt request for a CPU. Software picks one of four trigger conditions through a 2-bit sense field in an 8-bit control register. The four conditions are a low level, any change, a falling edge and a rising edge. The pin passes through a two-flop synchronizer. A further register keeps the previous synchronized sample, and edges are detected by comparing the two samples.

The edge modes set a sticky pending flag. Software clears that flag either by writing 1 to it or by pulsing the acknowledge input. The low-level mode latches nothing: the request simply follows the synchronized pin. In every mode the request reaches `irq_o` only when the interrupt's own enable bit and the global interrupt-enable input are both 1. Detection does not depend on the pin's direction, so software that drives the pin itself can raise the interrupt.

The register bus is a plain synchronous write port with a combinational read. Address 0 holds the control register, with the sense field in bits 1:0. Address 1 holds the enable bit in bit 0. Address 2 holds the pending flag in bit 0, and writing 1 to that bit clears it. Every bit not named here reads 0.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all three registers read 0 and `irq_o` is 0.
- R2: In the control register, only bits 1:0 hold a value. Writing 0xFF to address 0 reads back as 0x03.
- R3: Sense 00 (low level) drives `irq_o` high two clock edges after the pin goes low. It stays high while the pin stays low and goes low two edges after the pin returns high. The pending flag stays 0 in this mode.
- R4: Sense 01 sets the pending flag on either edge of the pin.
- R5: Sense 10 sets the pending flag on a falling edge only. The flag is visible on `irq_o` three clock edges after the pin changes and not after two.
- R6: Sense 11 sets the pending flag on a rising edge only.
- R7: In an edge mode, a pin pulse longer than one clock period sets the pending flag.
- R8: `irq_o` is 1 only when the enable bit (address 1, bit 0) is 1 and `gie_i` is 1. The pending flag sets whatever those two are, and it is presented once both are 1.
- R9: The pending flag clears on an `ack_i` pulse or on a write of 1 to address 2, bit 0. A write of 0 leaves it unchanged. A new edge in the same cycle as a clear wins, and the flag stays set.
- R10: No edge event is taken in a cycle that writes the control register. Switching from level mode to an edge mode while the pin is held low sets no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | External interrupt pin (asynchronous) |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | CPU acknowledge pulse; clears the pending flag |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Gated interrupt request |

## Verification
A synchronizer stage that is wrong or missing moves the response by one clock edge. The bench therefore checks the cycle before and the cycle of the expected change: two edges in level mode and three in the edge modes. A bad pending register shows up at address 2 and at `irq_o` on the edge after the event or clear that should have changed it. A missing gate shows up as `irq_o` high while the enable bit or `gie_i` is 0. A missing write blank shows up one cycle after the write, as a flag that should have stayed 0.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd2;

  // Edge condition for a mode, given the previous and current sample.
  function automatic logic edge_match(sense_e mode, logic prev, logic cur);
    case (mode)
      SENSE_ANY:  return prev ^ cur;
      SENSE_FALL: return prev & ~cur;
      SENSE_RISE: return ~prev & cur;
      default:    return 1'b0;
    endcase
  endfunction

  // Final request gate.
  function automatic logic gate_req(logic req, logic mask, logic gie);
    return req & mask & gie;
  endfunction
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int STAGES = 2,
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_s,
  output logic pin_prev
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= IDLE;
          else        chain[0] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= IDLE;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  // Previous sample, reloaded every cycle.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_prev <= IDLE;
    else        pin_prev <= chain[STAGES-1];

  assign pin_s = chain[STAGES-1];
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import ext_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              pending_i,
  output sense_e            sense_o,
  output logic              mask_o,
  output logic              ctrl_wr_o,
  output logic              flag_w1c_o,
  output logic [REG_W-1:0]  bus_rdata
);
  logic mask_wr;

  assign ctrl_wr_o  = bus_wr && (bus_addr == A_CTRL);
  assign mask_wr    = bus_wr && (bus_addr == A_MASK);
  assign flag_w1c_o = bus_wr && (bus_addr == A_FLAG) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sense_o <= SENSE_LOW;
      mask_o  <= 1'b0;
    end else begin
      if (ctrl_wr_o) sense_o <= sense_e'(bus_wdata[1:0]);
      if (mask_wr)   mask_o  <= bus_wdata[0];
    end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[1:0] = sense_o;
      A_MASK:  bus_rdata[0]   = mask_o;
      A_FLAG:  bus_rdata[0]   = pending_i;
      default: bus_rdata      = '0;
    endcase
  end
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e sense,
  input  logic   pin_s,
  input  logic   pin_prev,
  input  logic   blank,
  input  logic   ack_i,
  input  logic   w1c,
  input  logic   mask,
  input  logic   gie,
  output logic   edge_evt_o,
  output logic   pending_o,
  output logic   irq_o
);
  logic raw_req;

  assign edge_evt_o = edge_match(sense, pin_prev, pin_s) && !blank;

  // Set beats clear so an edge is never lost.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pending_o <= 1'b0;
    else if (edge_evt_o)       pending_o <= 1'b1;
    else if (ack_i || w1c)     pending_o <= 1'b0;

  assign raw_req = (sense == SENSE_LOW) ? ~pin_s : pending_o;
  assign irq_o   = gate_req(raw_req, mask, gie);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              gie_i,
  input  logic              ack_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_o
);
  logic   pin_s, pin_prev;
  sense_e sense;
  logic   mask, ctrl_wr, flag_w1c, edge_evt, pending;

  eirq_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .pin_s(pin_s), .pin_prev(pin_prev)
  );

  eirq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pending_i(pending), .sense_o(sense),
    .mask_o(mask), .ctrl_wr_o(ctrl_wr), .flag_w1c_o(flag_w1c),
    .bus_rdata(bus_rdata)
  );

  eirq_detect u_det (
    .clk(clk), .rst_n(rst_n), .sense(sense), .pin_s(pin_s),
    .pin_prev(pin_prev), .blank(ctrl_wr), .ack_i(ack_i), .w1c(flag_w1c),
    .mask(mask), .gie(gie_i), .edge_evt_o(edge_evt),
    .pending_o(pending), .irq_o(irq_o)
  );
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk
  import ext_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              gie_i,
  input logic              ack_i,
  input logic              mask,
  input logic [1:0]        sense,
  input logic              pin_s,
  input logic              edge_evt,
  input logic              pending,
  input logic              ctrl_wr,
  input logic              irq_o,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_rdata
);
  p_reset_clear_r1: assert property (@(posedge clk) $rose(rst_n) |-> !pending && !irq_o);

  p_ctrl_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[7:2] == 6'd0));

  p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == 2'b00 && mask && gie_i) |-> (irq_o == !pin_s));

  p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> pending);

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask && gie_i));

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !edge_evt) |=> !pending);

  p_write_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !pending) |=> !pending);
endmodule

bind ext_irq_sense ext_irq_sense_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie_i(gie_i), .ack_i(ack_i), .mask(mask),
  .sense(sense), .pin_s(pin_s), .edge_evt(edge_evt), .pending(pending),
  .ctrl_wr(ctrl_wr), .irq_o(irq_o), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic       gie = 1'b0;
  logic       ack = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_sense u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .gie_i(gie), .ack_i(ack),
    .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    cyc(1);
    wr = 1'b0; addr = 2'd0;
  endtask

  task automatic rreg(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    chk(irq == exp, tag, irq, exp);
  endtask

  task automatic do_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  task automatic t_reset();
    rreg(2'd0, 8'h00, "R1 ctrl");
    rreg(2'd1, 8'h00, "R1 mask");
    rreg(2'd2, 8'h00, "R1 flag");
    chk_irq(1'b0, "R1 irq");
  endtask

  task automatic t_ctrl_bits();
    wreg(2'd0, 8'hFF);
    rreg(2'd0, 8'h03, "R2 readback");
    wreg(2'd0, 8'h00);
    rreg(2'd0, 8'h00, "R2 cleared");
  endtask

  task automatic t_level();
    pin = 1'b0; cyc(1);
    chk_irq(1'b0, "R3 one edge");
    cyc(1);
    chk_irq(1'b1, "R3 two edges");
    cyc(4);
    chk_irq(1'b1, "R3 held low");
    rreg(2'd2, 8'h00, "R3 no latch");
    pin = 1'b1; cyc(2);
    chk_irq(1'b0, "R3 release");
  endtask

  task automatic t_any();
    wreg(2'd0, 8'h01);
    pin = 1'b0; cyc(3);
    chk_irq(1'b1, "R4 fall");
    wreg(2'd2, 8'h01);
    chk_irq(1'b0, "R4 w1c");
    pin = 1'b1; cyc(3);
    chk_irq(1'b1, "R4 rise");
    do_ack();
    chk_irq(1'b0, "R4 ack");
  endtask

  task automatic t_fall();
    wreg(2'd0, 8'h02);
    pin = 1'b0; cyc(2);
    chk_irq(1'b0, "R5 early");
    cyc(1);
    chk_irq(1'b1, "R5 fall");
    do_ack();
    pin = 1'b1; cyc(4);
    chk_irq(1'b0, "R5 rise ignored");
  endtask

  task automatic t_rise();
    wreg(2'd0, 8'h03);
    pin = 1'b0; cyc(4);
    chk_irq(1'b0, "R6 fall ignored");
    pin = 1'b1; cyc(3);
    chk_irq(1'b1, "R6 rise");
    do_ack();
  endtask

  task automatic t_pulse();
    wreg(2'd0, 8'h02);
    pin = 1'b0; #15; pin = 1'b1;
    cyc(4);
    rreg(2'd2, 8'h01, "R7 short pulse");
    do_ack();
  endtask

  task automatic t_gate();
    wreg(2'd1, 8'h00);
    pin = 1'b0; cyc(3); pin = 1'b1; cyc(3);
    chk_irq(1'b0, "R8 mask off");
    rreg(2'd2, 8'h01, "R8 flag set");
    wreg(2'd1, 8'h01);
    chk_irq(1'b1, "R8 mask on");
    gie = 1'b0; #1;
    chk_irq(1'b0, "R8 gie off");
    gie = 1'b1;
    do_ack();
  endtask

  task automatic t_clear();
    pin = 1'b0; cyc(3);
    wreg(2'd2, 8'h00);
    rreg(2'd2, 8'h01, "R9 write0 ignored");
    do_ack();
    rreg(2'd2, 8'h00, "R9 ack");
    pin = 1'b1; cyc(1);
    pin = 1'b0; cyc(2);
    do_ack();
    rreg(2'd2, 8'h01, "R9 set wins");
    do_ack();
    pin = 1'b1; cyc(3);
  endtask

  task automatic t_blank();
    pin = 1'b0; cyc(2);
    wreg(2'd0, 8'h02);
    rreg(2'd2, 8'h00, "R10 write blank");
    wreg(2'd0, 8'h00);
    cyc(2);
    wreg(2'd0, 8'h02);
    cyc(3);
    rreg(2'd2, 8'h00, "R10 level to edge");
    pin = 1'b1; cyc(3);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_ctrl_bits();
    gie = 1'b1;
    wreg(2'd1, 8'h01);
    t_level();
    t_any();
    t_fall();
    t_rise();
    t_pulse();
    t_gate();
    t_clear();
    t_blank();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule